// File: doc/BRIEF.md
# Partial Flags Stall Detector

This block sits beside the issue stage of an out-of-order core and decides when an instruction that consumes condition flags has to wait. It remembers the most recent flag-writing operation: its class, which of the six arithmetic flags that class leaves covered, and whether any read at all must wait for it. When a flag consumer then issues, the block compares the consumer's read set with that record. If merging older and newer flag values would be required, it raises a stall for a fixed penalty window. It does not compute flag values.

A writer that sets every flag in the normal way leaves nothing to merge. It also cancels any earlier partial writer. The writers that create a hazard are increment/decrement, carry set/clear/complement, direction and interrupt flag changes, test, bit test, bit scan, multiply, loading flags from a byte register, and shifts and rotates. A shift by exactly one in its short form makes no selective reads wait. A multi-bit or register-count shift makes every flag read wait. The stall ends when the penalty window runs out, or earlier when the recorded writer is reported retired.

The controller has three states. ST_IDLE means no partial writer is recorded. ST_ARMED means a partial writer is recorded. ST_STALL means a consumer is held. The transitions are:
- ST_IDLE to ST_ARMED on a partial writer.
- ST_ARMED to ST_STALL on a conflicting read.
- ST_ARMED to ST_IDLE on a full writer or on retire.
- ST_ARMED to ST_ARMED on another partial writer, which replaces the record.
- ST_STALL to ST_IDLE on retire or when the penalty expires.

Top module: `partial_flags_stall`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stall` is 0 and `penalty` is 0.
- R2: The class codes on `wr_class` are 0 none, 1 full writer, 2 increment/decrement, 3 carry set/clear/complement, 4 direction/interrupt flag change, 5 test/bit test/bit scan/multiply, 6 load flags from byte, 7 shift/rotate. The bits of `rd_mask` are bit0 carry, bit1 parity, bit2 auxiliary, bit3 zero, bit4 sign, bit5 overflow. After class 2, a read that includes carry stalls, and a read of only zero does not stall.
- R3: A read that includes any flag the recorded partial writer left unmodified stalls, even if it reads nothing else. Examples: zero after class 3, and overflow after class 6.
- R4: A whole-register read (`rd_all`=1) stalls after any partial class (2 to 7). Selective reads after class 4 or class 5 do not stall.
- R5: A read after a class 1 writer never stalls, and a class 1 writer cancels any recorded partial writer.
- R6: After class 7 with `wr_short_shift`=1, only whole-register reads stall. With `wr_short_shift`=0, any read with a nonzero mask stalls.
- R7: `stall` rises in the cycle after the conflicting read and stays high for PENALTY cycles. During that time `penalty` shows PENALTY, PENALTY-1, ..., 1. `penalty` is 0 whenever `stall` is 0.
- R8: `retire` during a stall drops `stall` in the next cycle. `retire` while a partial writer is recorded, with no write in that cycle, clears the record.
- R9: While stalled, writes and reads are ignored, and leaving the stall clears the record. A write issued together with a conflicting read is dropped. A write in the same cycle as `retire` is recorded.
- R10: A read with an empty mask and `rd_all`=0 never stalls. A class 0 write leaves the record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A flag-writing operation issues this cycle |
| wr_class | input | 3 | Writer class code (see R2) |
| wr_short_shift | input | 1 | Shift/rotate is the short form by exactly one |
| rd_valid | input | 1 | A flag-consuming operation issues this cycle |
| rd_mask | input | 6 | Flags read by the consumer (see R2) |
| rd_all | input | 1 | Consumer reads the whole flags register |
| retire | input | 1 | The recorded flag writer has retired |
| stall | output | 1 | Consumer must hold |
| penalty | output | CW | Remaining stall cycles, 0 when not stalled |

## Verification
Every result is due exactly one clock after the inputs that cause it: the stall decision, the penalty load, each countdown step and the early release on retire. The bench drives each cycle's inputs at the falling edge and advances its own reference model at the same moment. At the next falling edge it compares `stall` and `penalty` with that model, so every check samples the state produced by the edge in between. Directed sequences cover the named class and mask combinations. A seeded random stream mixes writes, reads, retires and collisions in the same cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int NFLAGS = 6;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_FULL     = 3'd1,
        OP_INCDEC   = 3'd2,
        OP_CARRY    = 3'd3,
        OP_SYSFLAG  = 3'd4,
        OP_TESTLIKE = 3'd5,
        OP_LOADAH   = 3'd6,
        OP_SHIFT    = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_STALL = 2'd2
    } pfs_state_e;

    typedef struct packed {
        logic              pending;
        logic              any_read;
        logic [NFLAGS-1:0] covered;
    } flag_rec_t;
endpackage

// File: rtl/pfs_class_decode.sv
module pfs_class_decode
    import pfs_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] cls,
    input  logic       short_shift,
    output logic       upd,
    output flag_rec_t  rec
);
    localparam logic [NFLAGS-1:0] ALL_F = {NFLAGS{1'b1}};

    always_comb begin
        upd = valid && (op_class_e'(cls) != OP_NONE);
        rec = '{pending: 1'b1, any_read: 1'b0, covered: ALL_F};
        unique case (op_class_e'(cls))
            OP_NONE:     rec.pending = 1'b0;
            OP_FULL:     rec.pending = 1'b0;
            OP_INCDEC:   rec.covered = ALL_F & ~6'b000001;
            OP_CARRY:    rec.covered = 6'b000001;
            OP_SYSFLAG:  rec.covered = ALL_F;
            OP_TESTLIKE: rec.covered = ALL_F;
            OP_LOADAH:   rec.covered = ALL_F & ~6'b100000;
            OP_SHIFT:    rec.any_read = ~short_shift;
        endcase
    end
endmodule

// File: rtl/pfs_conflict.sv
module pfs_conflict
    import pfs_pkg::*;
(
    input  flag_rec_t         rec,
    input  logic              rd_valid,
    input  logic [NFLAGS-1:0] rd_mask,
    input  logic              rd_all,
    output logic              conflict
);
    logic [NFLAGS-1:0] gap;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_gap
        assign gap[i] = rd_mask[i] & ~rec.covered[i];
    end

    always_comb begin
        conflict = rd_valid && rec.pending &&
                   (rd_all || (rec.any_read && (|rd_mask)) || (|gap));
    end
endmodule

// File: rtl/pfs_penalty_timer.sv
module pfs_penalty_timer #(
    parameter int PENALTY = 4,
    parameter int CW      = $clog2(PENALTY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          expire
);
    localparam logic [CW-1:0] LOADV = CW'(PENALTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      count <= '0;
        else if (clear)                  count <= '0;
        else if (load)                   count <= LOADV;
        else if (run && count != '0)     count <= count - 1'b1;
    end

    assign expire = (count == CW'(1));
endmodule

// File: rtl/partial_flags_stall.sv
module partial_flags_stall
    import pfs_pkg::*;
#(
    parameter int PENALTY = 4,
    parameter int CW      = $clog2(PENALTY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [2:0]    wr_class,
    input  logic          wr_short_shift,
    input  logic          rd_valid,
    input  logic [5:0]    rd_mask,
    input  logic          rd_all,
    input  logic          retire,
    output logic          stall,
    output logic [CW-1:0] penalty
);
    pfs_state_e state_q, state_d;
    flag_rec_t  rec_q, rec_d, dec_rec;
    logic       dec_upd, conflict, expire;
    logic       t_load, t_run, t_clear;
    logic [CW-1:0] count;

    pfs_class_decode u_dec (
        .valid       (wr_valid),
        .cls         (wr_class),
        .short_shift (wr_short_shift),
        .upd         (dec_upd),
        .rec         (dec_rec)
    );

    pfs_conflict u_cmp (
        .rec      (rec_q),
        .rd_valid (rd_valid),
        .rd_mask  (rd_mask),
        .rd_all   (rd_all),
        .conflict (conflict)
    );

    pfs_penalty_timer #(.PENALTY(PENALTY), .CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .run    (t_run),
        .clear  (t_clear),
        .count  (count),
        .expire (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
        end
    end

    // Next state, record and timer control
    always_comb begin
        state_d = state_q;
        rec_d   = rec_q;
        t_load  = 1'b0;
        t_run   = 1'b0;
        t_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (dec_upd) begin
                    rec_d   = dec_rec;
                    state_d = dec_rec.pending ? ST_ARMED : ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (conflict) begin
                    state_d = ST_STALL;
                    t_load  = 1'b1;
                end else if (dec_upd) begin
                    rec_d   = dec_rec;
                    state_d = dec_rec.pending ? ST_ARMED : ST_IDLE;
                end else if (retire) begin
                    rec_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            ST_STALL: begin
                if (retire || expire) begin
                    rec_d   = '0;
                    state_d = ST_IDLE;
                    t_clear = 1'b1;
                end else begin
                    t_run = 1'b1;
                end
            end
            default: begin
                rec_d   = '0;
                state_d = ST_IDLE;
                t_clear = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        stall   = (state_q == ST_STALL);
        penalty = count;
    end
endmodule

// File: rtl/partial_flags_stall_chk.sv
module partial_flags_stall_chk #(
    parameter int PENALTY = 4,
    parameter int CW      = $clog2(PENALTY + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic [2:0]    wr_class,
    input logic          rd_valid,
    input logic [5:0]    rd_mask,
    input logic          rd_all,
    input logic          retire,
    input logic          stall,
    input logic [CW-1:0] penalty
);
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> penalty == '0);

    p_stall_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (penalty != '0 && penalty <= CW'(PENALTY)));

    p_rise_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> penalty == CW'(PENALTY));

    p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !retire && penalty > CW'(1)) |=>
            (stall && penalty == $past(penalty) - CW'(1)));

    p_retire_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && retire) |=> !stall);

    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !(rd_valid && (rd_all || rd_mask != 6'd0))) |=> !stall);

    p_full_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && wr_valid && wr_class == 3'd1 && !rd_valid)
            ##1 (rd_valid && !wr_valid) |=> !stall);
endmodule

bind partial_flags_stall partial_flags_stall_chk #(.PENALTY(PENALTY), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_class (wr_class),
    .rd_valid (rd_valid),
    .rd_mask  (rd_mask),
    .rd_all   (rd_all),
    .retire   (retire),
    .stall    (stall),
    .penalty  (penalty)
);

// File: tb/partial_flags_stall_bench.sv
module partial_flags_stall_bench;
    localparam int PEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_class = 3'd0;
    logic       wr_short_shift = 1'b0;
    logic       rd_valid = 1'b0;
    logic [5:0] rd_mask = 6'd0;
    logic       rd_all = 1'b0;
    logic       retire = 1'b0;
    logic       stall;
    logic [2:0] penalty;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int       m_left = 0;
    bit       m_pend = 0;
    bit       m_any  = 0;
    bit [5:0] m_cov  = 6'h3f;

    always #10ns clk = ~clk;

    partial_flags_stall #(.PENALTY(PEN)) u_partial_flags_stall (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_class       (wr_class),
        .wr_short_shift (wr_short_shift),
        .rd_valid       (rd_valid),
        .rd_mask        (rd_mask),
        .rd_all         (rd_all),
        .retire         (retire),
        .stall          (stall),
        .penalty        (penalty)
    );

    // Flags each class leaves in a state a selective read may use (R2..R6)
    function automatic bit [5:0] cov_of(input bit [2:0] c);
        case (c)
            3'd2:    return 6'b111110;
            3'd3:    return 6'b000001;
            3'd6:    return 6'b011111;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic bit conflict_m(input bit rv, input bit [5:0] mk, input bit al);
        return rv && m_pend && (al || (m_any && mk != 0) || ((mk & ~m_cov) != 0));
    endfunction

    task automatic check(input string tag);
        bit       es = (m_left > 0);
        bit [2:0] ep = 3'(m_left);
        checks++;
        if (stall !== es || penalty !== ep) begin
            fails++;
            $display("FAIL %s: stall=%0b penalty=%0d expected stall=%0b penalty=%0d",
                     tag, stall, penalty, es, ep);
        end
    endtask

    // One cycle: check current outputs, drive inputs, advance the model
    task automatic cyc(input bit wv, input bit [2:0] cl, input bit sh,
                       input bit rv, input bit [5:0] mk, input bit al,
                       input bit rt, input string tag);
        check(tag);
        wr_valid = wv; wr_class = cl; wr_short_shift = sh;
        rd_valid = rv; rd_mask = mk; rd_all = al; retire = rt;
        if (m_left > 0) begin
            if (rt || m_left == 1) begin m_left = 0; m_pend = 0; end
            else m_left--;
        end else if (conflict_m(rv, mk, al)) begin
            m_left = PEN;
        end else if (wv && cl != 3'd0) begin
            m_pend = (cl != 3'd1);
            m_cov  = cov_of(cl);
            m_any  = (cl == 3'd7) && !sh;
        end else if (rt) begin
            m_pend = 0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input bit [2:0] cl, input bit sh, input string tag);
        cyc(1, cl, sh, 0, 6'd0, 0, 0, tag);
    endtask
    task automatic rd(input bit [5:0] mk, input bit al, input string tag);
        cyc(0, 3'd0, 0, 1, mk, al, 0, tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 0, 6'd0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (stall !== 1'b0 || penalty !== 3'd0) begin
            fails++;
            $display("FAIL R1: stall=%0b penalty=%0d expected stall=0 penalty=0", stall, penalty);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: increment then zero-only read, then carry read
        wr(3'd2, 0, "R2"); rd(6'h08, 0, "R2"); rd(6'h01, 0, "R2");
        idle(6, "R7");
        // R3: clear carry then zero read; byte load then overflow read, retired early
        wr(3'd3, 0, "R3"); rd(6'h08, 0, "R3"); idle(6, "R3");
        wr(3'd6, 0, "R3"); rd(6'h20, 0, "R3");
        cyc(0, 3'd0, 0, 0, 6'd0, 0, 1, "R8"); idle(3, "R8");
        // R4: direction change / test-like, selective vs whole reads
        wr(3'd4, 0, "R4"); rd(6'h08, 0, "R4"); rd(6'h00, 1, "R4"); idle(6, "R4");
        wr(3'd5, 0, "R4"); rd(6'h3f, 0, "R4"); rd(6'h00, 1, "R4"); idle(6, "R4");
        // R5: full writer cancels
        wr(3'd2, 0, "R5"); wr(3'd1, 0, "R5"); rd(6'h00, 1, "R5"); rd(6'h01, 0, "R5"); idle(2, "R5");
        // R6: short and long shifts
        wr(3'd7, 1, "R6"); rd(6'h08, 0, "R6"); rd(6'h01, 0, "R6"); rd(6'h00, 1, "R6"); idle(6, "R6");
        wr(3'd7, 0, "R6"); rd(6'h08, 0, "R6"); idle(6, "R6");
        // R8: retire clears record
        wr(3'd2, 0, "R8"); cyc(0, 3'd0, 0, 0, 6'd0, 0, 1, "R8"); rd(6'h01, 0, "R8"); idle(2, "R8");
        // R9: dropped write, writes during stall, write beats retire
        wr(3'd2, 0, "R9"); cyc(1, 3'd1, 0, 1, 6'h01, 0, 0, "R9");
        wr(3'd2, 0, "R9"); idle(5, "R9"); rd(6'h01, 0, "R9"); idle(2, "R9");
        cyc(1, 3'd3, 0, 0, 6'd0, 0, 1, "R9"); rd(6'h08, 0, "R9"); idle(6, "R9");
        // R10: empty read, no-op write keeps record
        wr(3'd2, 0, "R10"); rd(6'h00, 0, "R10"); wr(3'd0, 0, "R10"); rd(6'h01, 0, "R10"); idle(6, "R10");

        // seeded random mix
        void'($urandom(32'h5eed_0042));
        for (int n = 0; n < 3000; n++) begin
            bit       wv = ($urandom % 2) == 0;
            bit [2:0] cl = 3'($urandom % 8);
            bit       sh = ($urandom % 2) == 0;
            bit       rv = ($urandom % 5) < 2;
            bit [5:0] mk = 6'($urandom);
            bit       al = ($urandom % 7) == 0;
            bit       rt = ($urandom % 10) == 0;
            cyc(wv, cl, sh, rv, mk, al, rt, "R7");
        end
        idle(6, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule